// File: doc/BRIEF.md
# PCS Receive Code-Group Decoder with Trailing-Bit Handling

This block sits behind the code-group aligner of a 100 Mb/s receive path. It takes one aligned 5-bit code group per clock and rebuilds the nibble-wide receive stream that a MAC expects: a data nibble, a data-valid flag and an error flag. The two code groups that open a stream, /J/ then /K/, come out as two preamble nibbles. Each data code group that follows is mapped back to its 4-bit value. The stream closes on /T/ (followed by /R/) or on a return to IDLE.

Frames need not end on an octet boundary. A 3-bit residual count is presented alongside the /T/ code group. It gives the number of bits (0 to 7) that follow the last whole octet. The data code groups that carry those bits have already been sent on the line. A count of 1 to 4 means the last data nibble is partial: it is still delivered, with its unused upper bit positions forced to 1. A count of 5 to 7 means two partial nibbles were sent. The first is delivered whole and the second is suppressed. A /J/ without a following /K/ is reported as a false carrier.

Output timing: the nibble for the code group sampled at clock edge k is registered at edge k+1. The one-group look-ahead is what allows a stream start to be confirmed and the residual rule to be applied to the last nibble.

Top module: `pcs_rx_decoder`

## Requirements
- R1: While no stream is in progress (including directly after reset), rx_dv=0, rx_er=0 and rxd=4'b0000.
- R2: A /J/ (5'b11000) immediately followed by /K/ (5'b10001) produces two consecutive nibbles 4'b0101 with rx_dv=1 and rx_er=0. rx_dv rises on the first of them, one clock after /J/ is sampled.
- R3: After the preamble, each data code group is output one clock after it is sampled, with rx_dv=1 and rx_er=0, as its nibble (hex nibble: code). 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101.
- R4: A code group inside a stream that is not one of the sixteen in R3 is output with rx_dv=1, rx_er=1 and rxd=4'b0000.
- R5: When /T/ (5'b01101) arrives with a residual count r of 1 to 4, the preceding data nibble is still delivered, with every bit position b >= r set to 1 (bit 0 is the first bit received).
- R6: When /T/ arrives with a residual count of 5 to 7, the data nibble directly before /T/ is withheld: rx_dv=0, rx_er=0 and rxd=0 in its slot.
- R7: With a residual count of 0, the last data nibble is delivered unchanged. rx_dv is 0 from the slot of /T/ onward. A stream ended by IDLE (5'b11111) delivers its last nibble unchanged, ignores the residual input, and drops rx_dv in the slot of the IDLE.
- R8: A /J/ not followed by /K/ yields one nibble with rx_dv=0, rx_er=1 and rxd=4'b1110. The decoder then returns to the state in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code-group clock, one group per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cg_in | input | 5 | Aligned received code group |
| res_bits | input | 3 | Residual bit count after the last whole octet, read while cg_in is /T/ |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error / false-carrier indication |

## Verification
The embedded assertions check the following on every cycle: idle outputs are zero, a rising rx_dv always carries a preamble pair, and a false-carrier flag always carries 4'b1110. They also check that invalid in-stream groups raise rx_er, that a short residual sets the top nibble bit, that a long residual withholds the slot, and that rx_dv is low two slots after a terminating group. Only the bench scenarios show the exact decoded value of every table entry, the precise pad pattern for each residual count, and the return to idle after a false carrier or an empty stream. The bench also shows that the residual input is ignored when a stream ends on IDLE.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;
  localparam int RES_W = 3;

  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE2 = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/pcs_rx_cg_decode.sv
module pcs_rx_cg_decode
  import pcs_rx_pkg::*;
(
  input  logic [CG_W-1:0]  cg_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             ok_o
);
  always_comb begin
    ok_o  = 1'b1;
    nib_o = '0;
    case (cg_i)
      5'b11110: nib_o = 4'h0;
      5'b01001: nib_o = 4'h1;
      5'b10100: nib_o = 4'h2;
      5'b10101: nib_o = 4'h3;
      5'b01010: nib_o = 4'h4;
      5'b01011: nib_o = 4'h5;
      5'b01110: nib_o = 4'h6;
      5'b01111: nib_o = 4'h7;
      5'b10010: nib_o = 4'h8;
      5'b10011: nib_o = 4'h9;
      5'b10110: nib_o = 4'hA;
      5'b10111: nib_o = 4'hB;
      5'b11010: nib_o = 4'hC;
      5'b11011: nib_o = 4'hD;
      5'b11100: nib_o = 4'hE;
      5'b11101: nib_o = 4'hF;
      default:  ok_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcs_rx_trail_pad.sv
module pcs_rx_trail_pad
  import pcs_rx_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  input  logic [RES_W-1:0] res_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             drop_o
);
  localparam logic [RES_W-1:0] RES_NIB = RES_W'(NIB_W);

  logic fill_en;
  assign fill_en = (res_i != '0) && (res_i <= RES_NIB);
  assign drop_o  = (res_i > RES_NIB);

  for (genvar b = 0; b < NIB_W; b++) begin : g_pad
    assign nib_o[b] = nib_i[b] | (fill_en && (RES_W'(b) >= res_i));
  end
endmodule

// File: rtl/pcs_rx_ctrl.sv
module pcs_rx_ctrl
  import pcs_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'b0101,
  parameter logic [NIB_W-1:0] FC_NIB  = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CG_W-1:0]  cg_i,
  input  logic [RES_W-1:0] res_i,
  output logic [CG_W-1:0]  hold_o,
  input  logic [NIB_W-1:0] hold_nib_i,
  input  logic             hold_ok_i,
  output logic [NIB_W-1:0] pad_in_o,
  input  logic [NIB_W-1:0] pad_nib_i,
  input  logic             pad_drop_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             dv_o,
  output logic             er_o
);
  rx_state_e        st_q, st_d;
  logic [CG_W-1:0]  hold_q;
  logic [NIB_W-1:0] rxd_q, rxd_d;
  logic             dv_q, dv_d, er_q, er_d;
  logic             in_k, in_t, in_idle, h_j;

  assign in_k    = (cg_i == CG_K);
  assign in_t    = (cg_i == CG_T);
  assign in_idle = (cg_i == CG_IDLE);
  assign h_j     = (hold_q == CG_J);
  assign hold_o  = hold_q;
  assign pad_in_o = hold_ok_i ? hold_nib_i : '0;

  always_comb begin
    st_d  = st_q;
    rxd_d = '0;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (h_j) begin
          if (in_k) begin
            rxd_d = PRE_NIB;
            dv_d  = 1'b1;
            st_d  = ST_PRE2;
          end else begin
            rxd_d = FC_NIB;
            er_d  = 1'b1;
          end
        end
      end
      ST_PRE2: begin
        rxd_d = PRE_NIB;
        dv_d  = 1'b1;
        st_d  = (in_t || in_idle) ? ST_IDLE : ST_DATA;
      end
      ST_DATA: begin
        dv_d  = 1'b1;
        er_d  = ~hold_ok_i;
        rxd_d = pad_in_o;
        if (in_t) begin
          st_d = ST_IDLE;
          if (pad_drop_i) begin
            dv_d  = 1'b0;
            er_d  = 1'b0;
            rxd_d = '0;
          end else begin
            rxd_d = pad_nib_i;
          end
        end else if (in_idle) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= CG_IDLE;
      rxd_q  <= '0;
      dv_q   <= 1'b0;
      er_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= cg_i;
      rxd_q  <= rxd_d;
      dv_q   <= dv_d;
      er_q   <= er_d;
    end
  end

  assign rxd_o = rxd_q;
  assign dv_o  = dv_q;
  assign er_o  = er_q;

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dv_q && !er_q) |-> (rxd_q == '0));
  // R2
  pre_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |-> (rxd_q == PRE_NIB));
  // R2
  pre_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv_q) |=> (dv_q && rxd_q == PRE_NIB));
  // R8
  fc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (er_q && !dv_q) |-> (rxd_q == FC_NIB));
  // R4
  bad_cg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && !hold_ok_i && !(in_t && res_i > 3'd4)) |=> (er_q && dv_q));
  // R5
  pad_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && in_t && res_i >= 3'd1 && res_i <= 3'd3) |=> (dv_q && rxd_q[NIB_W-1]));
  // R6
  drop_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && in_t && res_i > 3'd4) |=> !dv_q);
  // R7
  end_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && (in_t || in_idle)) |=> ##1 !dv_q);
endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
  import pcs_rx_pkg::*;
#(
  parameter logic [3:0] PRE_NIB = 4'b0101,
  parameter logic [3:0] FC_NIB  = 4'b1110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] cg_in,
  input  logic [2:0] res_bits,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = sync_q[SYNC_STAGES-1];

  logic [CG_W-1:0]  hold_cg;
  logic [NIB_W-1:0] hold_nib, pad_in, pad_nib;
  logic             hold_ok, pad_drop;

  pcs_rx_cg_decode i_dec (
    .cg_i  (hold_cg),
    .nib_o (hold_nib),
    .ok_o  (hold_ok)
  );

  pcs_rx_trail_pad i_pad (
    .nib_i  (pad_in),
    .res_i  (res_bits),
    .nib_o  (pad_nib),
    .drop_o (pad_drop)
  );

  pcs_rx_ctrl #(.PRE_NIB(PRE_NIB), .FC_NIB(FC_NIB)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cg_i       (cg_in),
    .res_i      (res_bits),
    .hold_o     (hold_cg),
    .hold_nib_i (hold_nib),
    .hold_ok_i  (hold_ok),
    .pad_in_o   (pad_in),
    .pad_nib_i  (pad_nib),
    .pad_drop_i (pad_drop),
    .rxd_o      (rxd),
    .dv_o       (rx_dv),
    .er_o       (rx_er)
  );
endmodule

// File: tb/test_pcs_rx_decoder.sv
`timescale 1ns/1ps
module test_pcs_rx_decoder;
  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] cg_in;
  logic [2:0] res_bits;
  logic [3:0] rxd;
  logic       rx_dv, rx_er;

  always #4 clk = ~clk;

  pcs_rx_decoder i_pcs_rx_decoder (
    .clk(clk), .rst_n(rst_n), .cg_in(cg_in), .res_bits(res_bits),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er)
  );

  logic [4:0] enc_tab [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};

  logic [4:0] s_q [$];
  int         r_q [$];
  logic [3:0] e_rxd [$];
  logic       e_dv [$], e_er [$];
  string      e_tag [$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic put(input logic [4:0] c, input int r = 0);
    s_q.push_back(c);
    r_q.push_back(r);
  endtask

  task automatic idles(input int n);
    for (int k = 0; k < n; k++) put(I, k % 8);
  endtask

  task automatic frame(input int nibs [$], input int res, input bit by_t);
    put(J); put(K);
    foreach (nibs[k]) put(enc_tab[nibs[k]], (k * 3) % 8);
    if (by_t) begin put(T, res); put(R); end
    else put(I, res);
    idles(3);
  endtask

  task automatic build_expected();
    int mode = 0;
    for (int j = 0; j < s_q.size() - 1; j++) begin
      logic [4:0] c, nx;
      logic [3:0] xr;
      logic xd, xe, found;
      int r;
      string tag;
      c = s_q[j]; nx = s_q[j+1]; r = r_q[j+1];
      xr = 4'h0; xd = 0; xe = 0; tag = "R1"; found = 0;
      case (mode)
        0: if (c == J) begin
             if (nx == K) begin xr = 4'b0101; xd = 1; tag = "R2"; mode = 1; end
             else begin xr = 4'b1110; xe = 1; tag = "R8"; end
           end
        1: begin
             xr = 4'b0101; xd = 1; tag = "R2";
             mode = (nx == T || nx == I) ? 0 : 2;
           end
        default: begin
          xd = 1;
          for (int v = 0; v < 16; v++)
            if (enc_tab[v] == c) begin xr = 4'(v); found = 1; end
          if (found) tag = "R3"; else begin xe = 1; tag = "R4"; end
          if (nx == T) begin
            mode = 0;
            if (r >= 5) begin xr = 0; xd = 0; xe = 0; tag = "R6"; end
            else if (r >= 1) begin
              for (int b = r; b < 4; b++) xr[b] = 1'b1;
              tag = "R5";
            end else tag = "R7";
          end else if (nx == I) begin
            mode = 0; tag = "R7";
          end
        end
      endcase
      e_rxd.push_back(xr); e_dv.push_back(xd); e_er.push_back(xe); e_tag.push_back(tag);
    end
  endtask

  task automatic check_slot(input int j);
    checks++;
    if (rxd !== e_rxd[j] || rx_dv !== e_dv[j] || rx_er !== e_er[j]) begin
      errors++;
      $display("FAIL %s group %0d: rxd=%h dv=%b er=%b expected rxd=%h dv=%b er=%b",
               e_tag[j], j, rxd, rx_dv, rx_er, e_rxd[j], e_dv[j], e_er[j]);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cg_in = I; res_bits = 3'd0;
    idles(5);
    frame('{5, 13, 1, 2}, 0, 1);                                          // R3 R7
    frame('{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,0}, 2, 1);              // R3 R5
    frame('{9, 6}, 4, 1);                                                 // R5 r=4
    frame('{3, 0}, 1, 1);                                                 // R5 r=1
    frame('{10, 11, 12, 7}, 5, 1);                                        // R6
    frame('{1, 8, 4}, 7, 1);                                              // R6
    frame('{2, 3, 0}, 3, 1);                                              // R5 r=3
    frame('{15, 14}, 6, 0);                                               // R7 idle end
    put(J); put(K); put(enc_tab[4]); put(5'b00000); put(enc_tab[7]); put(T, 0); put(R); // R4
    idles(3);
    put(J); put(enc_tab[4]); put(enc_tab[5]); idles(3);                   // R8
    put(J); put(K); put(T, 2); put(R); idles(3);                          // R2 empty
    idles(4);
    build_expected();

    repeat (3) @(negedge clk);
    checks++;                                                             // R1 reset
    if (rxd !== 4'h0 || rx_dv !== 1'b0 || rx_er !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: rxd=%h dv=%b er=%b expected rxd=0 dv=0 er=0", rxd, rx_dv, rx_er);
    end
    rst_n = 1'b1;

    for (int i = 0; i < s_q.size() + 1; i++) begin
      @(negedge clk);
      if (i >= 2 && (i - 2) < e_rxd.size()) check_slot(i - 2);
      cg_in    = (i < s_q.size()) ? s_q[i] : I;
      res_bits = (i < s_q.size()) ? 3'(r_q[i]) : 3'd0;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule